// File: doc/BRIEF.md
# Dual-Antenna Acquisition Dwell Controller

This block runs preamble acquisition for a receiver with two antennas. While it scans, it gives each antenna a fixed dwell in turn, A1 first and then A2, and it drives the antenna-select line to match. A dwell is counted in symbol strobes, not in clock cycles. The correlator and the signal-quality estimators sit outside the block. On the final strobe of each dwell they present the following, which the block records for the antenna just observed:

- a signal-quality level,
- two threshold pass flags,
- a symbol-timing estimate,
- a carrier-frequency estimate.

After each A1/A2 pair the block makes a decision. An antenna counts as a candidate only if both of its pass flags were set. The candidate with the higher level wins, and A1 wins a tie. The timing and frequency recorded for the winner are latched and placed on the outputs. The block then enters tracking: it enables the carrier NCO, switches from differential to coherent demodulation and never moves the antenna select again. If no antenna qualifies, scanning resumes on A1.

In single-antenna mode the A2 dwells are left out, so a decision follows every A1 dwell. A detection in this mode is not trusted at once. One further dwell on A1 must also pass both flags before tracking starts. If that dwell fails, the block pulses a failure output for one cycle and resumes scanning.

Top module: `acq_dwell_ctrl`

## Requirements
- R1: After reset, ant_sel_o, nco_en_o, coherent_o, acq_fail_o and lock_ant_o are all 0, and the block waits for start_i before its first dwell.
- R2: A dwell ends on its SYMS-th (16 by default) sym_stb_i. Cycles without a strobe do not advance it. In dual mode ant_sel_o goes from 0 (A1) to 1 (A2) only when the A1 dwell ends.
- R3: In dual mode, if neither antenna qualifies at the end of an A2 dwell, the block returns to an A1 dwell with ant_sel_o=0, nco_en_o=0 and no acq_fail_o pulse.
- R4: An antenna qualifies only when sq1_ok_i and sq2_ok_i were both 1 at the end of its dwell. A dwell that passes only one of the two flags never leads to tracking.
- R5: Among the qualifying antennas, the one with the larger sq_level_i is chosen. Equal levels choose A1. lock_ant_o and ant_sel_o then show the choice (0=A1, 1=A2).
- R6: In tracking, timing_o and freq_o equal the sym_timing_i and freq_est_i that were presented at the end of the chosen antenna's decisive dwell.
- R7: In single mode ant_sel_o stays 0. A detection is followed by one verification dwell on A1. If that dwell qualifies, tracking starts in the cycle after its last strobe.
- R8: If the verification dwell does not qualify, acq_fail_o is 1 for exactly one cycle, starting the cycle after the last strobe, and an A1 dwell restarts.
- R9: nco_en_o and coherent_o are 0 before tracking and 1 in tracking. Tracking holds ant_sel_o, lock_ant_o, timing_o and freq_o fixed regardless of strobes or new estimates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin acquisition (sampled in idle) |
| single_ant_i | input | 1 | 1 = single-antenna mode with verification dwell |
| sym_stb_i | input | 1 | One pulse per received symbol |
| sq_level_i | input | QW | Signal-quality level of the dwell ending now |
| sq1_ok_i | input | 1 | Correlation-amplitude measure passed its threshold |
| sq2_ok_i | input | 1 | Phase-noise measure passed its threshold |
| sym_timing_i | input | TW | Symbol-timing estimate of the current dwell |
| freq_est_i | input | FW | Carrier-frequency estimate of the current dwell |
| ant_sel_o | output | 1 | Antenna select, 0 = A1, 1 = A2 |
| nco_en_o | output | 1 | Carrier NCO enable |
| coherent_o | output | 1 | 1 = coherent demodulation, 0 = differential |
| acq_fail_o | output | 1 | One-cycle pulse when verification fails |
| lock_ant_o | output | 1 | Antenna chosen at the last detection |
| timing_o | output | TW | Latched symbol timing of the chosen antenna |
| freq_o | output | FW | Latched frequency estimate of the chosen antenna |

## Verification
The bench builds the block with its default parameters: a 16-strobe dwell, a 16-bit quality level, 5-bit timing and 12-bit frequency. A full-length dwell therefore tests the exact strobe boundary of R2, with idle cycles placed between strobes. Small distinct level, timing and frequency values make it possible to tell which antenna's record was latched in the tie, A1-wins and A2-wins cases. In single mode, a verification failure followed by a successful retry reaches both the failure pulse and the path into tracking.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DWELL_A1,
    ST_DWELL_A2,
    ST_DECIDE,
    ST_VERIFY,
    ST_TRACK
  } acq_state_e;

  localparam int unsigned N_ANT = 2;
  localparam logic ANT_A1 = 1'b0;
  localparam logic ANT_A2 = 1'b1;
endpackage

// File: rtl/acq_dwell_cnt.sv
module acq_dwell_cnt #(
  parameter int unsigned SYMS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stb_i,
  output logic last_o
);
  localparam int unsigned CW = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SYMS - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = en_i && stb_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (stb_i)    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
  end

  p_hold_no_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stb_i) |=> $stable(cnt_q));
  p_wrap_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == '0));
endmodule

// File: rtl/acq_ant_rec.sv
module acq_ant_rec
  import acq_pkg::*;
#(
  parameter int unsigned QW = 16,
  parameter int unsigned TW = 5,
  parameter int unsigned FW = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_ANT-1:0]           cap_i,
  input  logic [QW-1:0]              q_i,
  input  logic                       ok_i,
  input  logic [TW-1:0]              tim_i,
  input  logic [FW-1:0]              frq_i,
  output logic [N_ANT-1:0][QW-1:0]   q_o,
  output logic [N_ANT-1:0]           ok_o,
  output logic [N_ANT-1:0][TW-1:0]   tim_o,
  output logic [N_ANT-1:0][FW-1:0]   frq_o
);
  for (genvar a = 0; a < N_ANT; a++) begin : g_ant
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o[a]   <= '0;
        ok_o[a]  <= 1'b0;
        tim_o[a] <= '0;
        frq_o[a] <= '0;
      end else if (cap_i[a]) begin
        q_o[a]   <= q_i;
        ok_o[a]  <= ok_i;
        tim_o[a] <= tim_i;
        frq_o[a] <= frq_i;
      end
    end
  end

  p_one_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cap_i) <= 1);
endmodule

// File: rtl/acq_pick.sv
module acq_pick
  import acq_pkg::*;
#(
  parameter int unsigned QW = 16
) (
  input  logic                     single_i,
  input  logic [N_ANT-1:0]         ok_i,
  input  logic [N_ANT-1:0][QW-1:0] q_i,
  output logic                     found_o,
  output logic                     pick_o
);
  logic a2_live;

  always_comb begin
    a2_live = !single_i && ok_i[ANT_A2];
    found_o = ok_i[ANT_A1] || a2_live;
    // strict compare: a tie goes to A1
    if (a2_live && (!ok_i[ANT_A1] || (q_i[ANT_A2] > q_i[ANT_A1]))) pick_o = ANT_A2;
    else                                                           pick_o = ANT_A1;
  end
endmodule

// File: rtl/acq_dwell_ctrl.sv
module acq_dwell_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned SYMS = 16,
  parameter int unsigned QW   = 16,
  parameter int unsigned TW   = 5,
  parameter int unsigned FW   = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          single_ant_i,
  input  logic          sym_stb_i,
  input  logic [QW-1:0] sq_level_i,
  input  logic          sq1_ok_i,
  input  logic          sq2_ok_i,
  input  logic [TW-1:0] sym_timing_i,
  input  logic [FW-1:0] freq_est_i,
  output logic          ant_sel_o,
  output logic          nco_en_o,
  output logic          coherent_o,
  output logic          acq_fail_o,
  output logic          lock_ant_o,
  output logic [TW-1:0] timing_o,
  output logic [FW-1:0] freq_o
);
  acq_state_e state_q, state_d;

  logic                     dwell_en, dwell_last, both_ok;
  logic [N_ANT-1:0]         cap;
  logic [N_ANT-1:0][QW-1:0] rec_q;
  logic [N_ANT-1:0]         rec_ok;
  logic [N_ANT-1:0][TW-1:0] rec_tim;
  logic [N_ANT-1:0][FW-1:0] rec_frq;
  logic                     found, pick;
  logic                     ant_q, ant_d, lock_q, fail_q;
  logic [TW-1:0]            tim_q;
  logic [FW-1:0]            frq_q;

  assign dwell_en = (state_q == ST_DWELL_A1) || (state_q == ST_DWELL_A2) ||
                    (state_q == ST_VERIFY);
  assign both_ok  = sq1_ok_i && sq2_ok_i;
  assign cap[ANT_A1] = (state_q == ST_DWELL_A1) && dwell_last;
  assign cap[ANT_A2] = (state_q == ST_DWELL_A2) && dwell_last;

  acq_dwell_cnt #(.SYMS(SYMS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (dwell_en),
    .stb_i (sym_stb_i),
    .last_o(dwell_last)
  );

  acq_ant_rec #(.QW(QW), .TW(TW), .FW(FW)) u_rec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .q_i   (sq_level_i),
    .ok_i  (both_ok),
    .tim_i (sym_timing_i),
    .frq_i (freq_est_i),
    .q_o   (rec_q),
    .ok_o  (rec_ok),
    .tim_o (rec_tim),
    .frq_o (rec_frq)
  );

  acq_pick #(.QW(QW)) u_pick (
    .single_i(single_ant_i),
    .ok_i    (rec_ok),
    .q_i     (rec_q),
    .found_o (found),
    .pick_o  (pick)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_DWELL_A1;
      ST_DWELL_A1: if (dwell_last) state_d = single_ant_i ? ST_DECIDE : ST_DWELL_A2;
      ST_DWELL_A2: if (dwell_last) state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (!found)            state_d = ST_DWELL_A1;
        else if (single_ant_i) state_d = ST_VERIFY;
        else                   state_d = ST_TRACK;
      end
      ST_VERIFY:   if (dwell_last) state_d = both_ok ? ST_TRACK : ST_DWELL_A1;
      ST_TRACK:    state_d = ST_TRACK;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ant_d = ant_q;
    if (state_d == ST_DWELL_A1 || state_d == ST_IDLE) ant_d = ANT_A1;
    else if (state_d == ST_DWELL_A2)                  ant_d = ANT_A2;
    else if (state_q == ST_DECIDE && found)           ant_d = pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ant_q   <= ANT_A1;
      lock_q  <= ANT_A1;
      tim_q   <= '0;
      frq_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ant_q   <= ant_d;
      fail_q  <= (state_q == ST_VERIFY) && dwell_last && !both_ok;
      if (state_q == ST_DECIDE && found) begin
        lock_q <= pick;
        tim_q  <= rec_tim[pick];
        frq_q  <= rec_frq[pick];
      end
    end
  end

  assign ant_sel_o  = ant_q;
  assign nco_en_o   = (state_q == ST_TRACK);
  assign coherent_o = (state_q == ST_TRACK);
  assign acq_fail_o = fail_q;
  assign lock_ant_o = lock_q;
  assign timing_o   = tim_q;
  assign freq_o     = frq_q;

  p_decide_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE) |=> (state_q != ST_DECIDE));
  p_no_find_rescan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && !rec_ok[ANT_A1] && !rec_ok[ANT_A2]) |=> (state_q == ST_DWELL_A1));
  p_single_skip_a2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DWELL_A1 && single_ant_i && dwell_last) |=> (state_q == ST_DECIDE));
  p_fail_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_fail_o |=> !acq_fail_o);
  p_fail_rescan_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_fail_o |-> (state_q == ST_DWELL_A1 && !ant_sel_o));
  p_track_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRACK) |=> (state_q == ST_TRACK && $stable(ant_sel_o) &&
                               $stable(timing_o) && $stable(freq_o)));
endmodule

// File: tb/sim_acq_dwell_ctrl.sv
module sim_acq_dwell_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SYMS = 16;
  localparam int QW = 16, TW = 5, FW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, single = 1'b0, stb = 1'b0;
  logic [QW-1:0] lvl = '0;
  logic ok1 = 1'b0, ok2 = 1'b0;
  logic [TW-1:0] tim = '0;
  logic [FW-1:0] frq = '0;
  logic ant_sel, nco_en, coh, fail, lock_ant;
  logic [TW-1:0] tim_o;
  logic [FW-1:0] frq_o;

  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_dwell_ctrl #(.SYMS(SYMS), .QW(QW), .TW(TW), .FW(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .single_ant_i(single),
    .sym_stb_i(stb), .sq_level_i(lvl), .sq1_ok_i(ok1), .sq2_ok_i(ok2),
    .sym_timing_i(tim), .freq_est_i(frq), .ant_sel_o(ant_sel), .nco_en_o(nco_en),
    .coherent_o(coh), .acq_fail_o(fail), .lock_ant_o(lock_ant),
    .timing_o(tim_o), .freq_o(frq_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; single = mode; start = 1'b0; stb = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic meas(input logic a, input logic b, input int q, input int t, input int f);
    ok1 = a; ok2 = b; lvl = QW'(q); tim = TW'(t); frq = FW'(f);
  endtask

  // idle cycle, then one strobe; returns half a cycle after the sampling edge
  task automatic strobe();
    @(negedge clk); stb = 1'b1; @(negedge clk); stb = 1'b0;
  endtask

  task automatic dwell(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk(ant_sel, 0, "R1 ant_sel"); chk(nco_en, 0, "R1 nco_en");
    chk(coh, 0, "R1 coherent"); chk(fail, 0, "R1 acq_fail"); chk(lock_ant, 0, "R1 lock_ant");
    dwell(20);
    chk(ant_sel, 0, "R1 no dwell before start");
  endtask

  task automatic t_dual_a1_wins();
    do_reset(1'b0); kick();
    meas(1, 1, 50, 5, 100);
    dwell(SYMS - 1);
    chk(ant_sel, 0, "R2 still A1 after SYMS-1 strobes");
    repeat (3) @(negedge clk);
    chk(ant_sel, 0, "R2 idle cycles do not end dwell");
    strobe();
    chk(ant_sel, 1, "R2 A2 after SYMS strobes");
    meas(1, 1, 30, 9, 200);
    dwell(SYMS);
    chk(nco_en, 0, "R9 nco off while deciding");
    @(negedge clk);
    chk(nco_en, 1, "R9 nco on in tracking"); chk(coh, 1, "R9 coherent in tracking");
    chk(lock_ant, 0, "R5 higher A1 chosen"); chk(ant_sel, 0, "R5 ant_sel on A1");
    chk(tim_o, 5, "R6 timing of A1"); chk(frq_o, 100, "R6 freq of A1");
    meas(1, 1, 999, 17, 333);
    dwell(2 * SYMS + 3);
    chk(ant_sel, 0, "R9 ant_sel frozen"); chk(nco_en, 1, "R9 still tracking");
    chk(tim_o, 5, "R9 timing frozen"); chk(frq_o, 100, "R9 freq frozen");
  endtask

  task automatic t_dual_none_then_a2();
    do_reset(1'b0); kick();
    meas(1, 0, 90, 1, 11); dwell(SYMS);
    meas(0, 1, 90, 2, 22); dwell(SYMS);
    chk(fail, 0, "R3 no fail pulse in dual scan");
    @(negedge clk);
    chk(ant_sel, 0, "R4 one-flag dwells rescan A1"); chk(nco_en, 0, "R3 not tracking");
    chk(fail, 0, "R3 no fail pulse");
    meas(1, 1, 40, 3, 33); dwell(SYMS);
    chk(ant_sel, 1, "R2 second pair A2");
    meas(1, 1, 80, 7, 77); dwell(SYMS);
    @(negedge clk);
    chk(nco_en, 1, "R5 tracking after A2 pass");
    chk(lock_ant, 1, "R5 higher A2 chosen"); chk(ant_sel, 1, "R5 ant_sel on A2");
    chk(tim_o, 7, "R6 timing of A2"); chk(frq_o, 77, "R6 freq of A2");
  endtask

  task automatic t_dual_tie();
    do_reset(1'b0); kick();
    meas(1, 1, 60, 4, 44); dwell(SYMS);
    meas(1, 1, 60, 8, 88); dwell(SYMS);
    @(negedge clk);
    chk(lock_ant, 0, "R5 tie picks A1"); chk(tim_o, 4, "R6 tie timing A1");
    chk(frq_o, 44, "R6 tie freq A1");
  endtask

  task automatic t_single_verify();
    do_reset(1'b1); kick();
    meas(1, 1, 70, 6, 66); dwell(SYMS);
    chk(ant_sel, 0, "R7 single stays A1");
    @(negedge clk);
    chk(nco_en, 0, "R7 verify before tracking");
    meas(1, 0, 70, 6, 66); dwell(SYMS);
    chk(fail, 1, "R8 fail pulse set"); chk(nco_en, 0, "R8 no tracking");
    @(negedge clk);
    chk(fail, 0, "R8 fail pulse one cycle"); chk(ant_sel, 0, "R8 rescan A1");
    meas(1, 1, 71, 12, 121); dwell(SYMS);
    chk(ant_sel, 0, "R7 single no A2 dwell");
    @(negedge clk);
    meas(1, 1, 5, 30, 999); dwell(SYMS);
    chk(nco_en, 1, "R7 tracking after verify pass"); chk(coh, 1, "R9 coherent on");
    chk(ant_sel, 0, "R7 A1 in single"); chk(tim_o, 12, "R6 single timing");
    chk(frq_o, 121, "R6 single freq"); chk(fail, 0, "R8 no pulse on pass");
  endtask

  initial begin
    t_reset();
    t_dual_a1_wins();
    t_dual_none_then_a2();
    t_dual_tie();
    t_single_verify();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule